// File: doc/BRIEF.md
# Control-Register File with Operating-Mode Tracker

This block keeps the processor's architectural control state: the paging and protection control word, the fault-address and translation-root words, the feature-control word, the task-priority word, the extended-feature word, the code-segment attribute and a time-stamp offset. A single port with an index, write data, a write strobe and a read strobe gives access to all of them. From this state the block derives the operating mode (legacy or long), a submode (real, virtual-8086, protected, compatibility or 64-bit) and the current privilege level.

Writes have side effects. When paging is switched on or off while long-mode enable is set, the long-mode-active flag follows the new paging bit. After every accepted write the submode is recomputed from the new state. Writes that change how translations are formed raise one-cycle flush pulses toward the instruction and data translation buffers. The time-stamp is held as an offset against a free-running cycle-count input, so reads return a value that keeps advancing.

Top module: `ctlmt_top`

## Requirements
- R1: After reset every register holds zero, so all reads return zero except index 0, which reads 0x10. `long_mode_o` is 0, `submode_o` is 0 (real), `cpl_o` is 0 and no flush or error pulse is raised.
- R2: A write to index 0 in which bit 31 (paging) differs from the stored value, while bit 8 (long-mode enable) of the extended-feature word (index 16) is 1, copies the new bit 31 into bit 10 (long-mode active) of index 16. `long_mode_o` shows that bit. A write to index 16 never changes bit 10.
- R3: Every accepted write updates `submode_o` from the new state and the `vm_flag_i` input. If long mode is active, the result is 4 (64-bit) when code-attribute bit 2 is 1 and 3 (compatibility) when it is 0. Otherwise it is 0 (real) when index-0 bit 0 is 0, 1 (virtual-8086) when `vm_flag_i` is 1, and 2 (protected) in the remaining case.
- R4: A write to index 0 that changes bit 31 raises both bits of `flush_all_o` for exactly the cycle after the write edge.
- R5: Bit 4 of index 0 always reads as 1, whatever value was written.
- R6: Every write to index 3 raises both bits of `flush_ng_o` for one cycle.
- R7: A write to index 4 raises `flush_all_o` only if it changes bit 4, 5 or 7. A change to any other bit raises no flush.
- R8: Index 17 stores only bits [2:0]. `cpl_o` equals the stored bits [1:0].
- R9: The legal indices are 0, 2, 3, 4, 8, 16, 17 and 18. A read or write of any other index raises `err_o` for one cycle, leaves all state unchanged and returns zero on a read.
- R10: A write to index 18 stores the write data minus `cycle_i`. A read returns the stored value plus `cycle_i`, taken at the edge of the access, modulo 2^64.
- R11: `rdata_o` is updated one cycle after a read strobe and then holds its value. A read and a write of the same index in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| idx_i | input | IDX_W (5) | Register index |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | XLEN (64) | Write data |
| cycle_i | input | XLEN (64) | Free-running cycle count |
| vm_flag_i | input | 1 | Virtual-8086 flag from the flags register |
| rdata_o | output | XLEN (64) | Registered read data |
| err_o | output | 1 | Illegal-index access pulse |
| long_mode_o | output | 1 | 1 = long mode, 0 = legacy |
| submode_o | output | 3 | Submode code (see R3) |
| cpl_o | output | 2 | Current privilege level |
| flush_all_o | output | NUM_TLB (2) | Full-flush pulse; bit 0 instruction, bit 1 data |
| flush_ng_o | output | NUM_TLB (2) | Non-global flush pulse; bit 0 instruction, bit 1 data |

## Verification
One write to index 0 can do two things in the same cycle: a change to the paging bit with long-mode enable set flips the long-mode flag and the submode, and it also raises the full flush on both buffers. The bench sweeps every combination of long-mode enable, protection enable, the code-segment long attribute and the virtual-8086 input. For each combination it switches paging on and then off, and after every write it compares the flush pulses, the mode and the submode with values computed from the requirements. A read and a write of the same index in one cycle is also exercised, and the read must return the value from before the write.

// File: rtl/ctlmt_pkg.sv
package ctlmt_pkg;

   typedef enum logic [2:0] {
      SM_REAL   = 3'd0,
      SM_V86    = 3'd1,
      SM_PROT   = 3'd2,
      SM_COMPAT = 3'd3,
      SM_WIDE   = 3'd4
   } submode_e;

   typedef enum logic [3:0] {
      SEL_C0, SEL_C2, SEL_C3, SEL_C4, SEL_C8,
      SEL_EXT, SEL_CSA, SEL_TOFS, SEL_NONE
   } sel_e;

   // index map
   localparam int unsigned IX_C0   = 0;
   localparam int unsigned IX_C2   = 2;
   localparam int unsigned IX_C3   = 3;
   localparam int unsigned IX_C4   = 4;
   localparam int unsigned IX_C8   = 8;
   localparam int unsigned IX_EXT  = 16;
   localparam int unsigned IX_CSA  = 17;
   localparam int unsigned IX_TOFS = 18;

   // bit positions that other logic decodes
   localparam int unsigned C0_PE   = 0;
   localparam int unsigned C0_ET   = 4;
   localparam int unsigned C0_PG   = 31;
   localparam int unsigned C4_PSE  = 4;
   localparam int unsigned C4_PAE  = 5;
   localparam int unsigned C4_PGE  = 7;
   localparam int unsigned EXT_LME = 8;
   localparam int unsigned EXT_LMA = 10;
   localparam int unsigned CSA_L   = 2;
   localparam int unsigned CSA_W   = 3;

   function automatic submode_e pick_submode(input logic lma, input logic l_attr,
                                             input logic pe, input logic vm);
      submode_e s;
      if (lma)      s = l_attr ? SM_WIDE : SM_COMPAT;
      else if (!pe) s = SM_REAL;
      else          s = vm ? SM_V86 : SM_PROT;
      return s;
   endfunction

endpackage

// File: rtl/ctlmt_decode.sv
module ctlmt_decode
   import ctlmt_pkg::*;
#(
   parameter int unsigned IDX_W = 5
) (
   input  logic [IDX_W-1:0] idx_i,
   output sel_e             sel_o,
   output logic             legal_o
);

   always_comb begin
      sel_o   = SEL_NONE;
      legal_o = 1'b1;
      if      (idx_i == IDX_W'(IX_C0))   sel_o = SEL_C0;
      else if (idx_i == IDX_W'(IX_C2))   sel_o = SEL_C2;
      else if (idx_i == IDX_W'(IX_C3))   sel_o = SEL_C3;
      else if (idx_i == IDX_W'(IX_C4))   sel_o = SEL_C4;
      else if (idx_i == IDX_W'(IX_C8))   sel_o = SEL_C8;
      else if (idx_i == IDX_W'(IX_EXT))  sel_o = SEL_EXT;
      else if (idx_i == IDX_W'(IX_CSA))  sel_o = SEL_CSA;
      else if (idx_i == IDX_W'(IX_TOFS)) sel_o = SEL_TOFS;
      else                               legal_o = 1'b0;
   end

endmodule

// File: rtl/ctlmt_flush.sv
module ctlmt_flush
   import ctlmt_pkg::*;
#(
   parameter int unsigned NUM_TLB = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_ok_i,
   input  sel_e               sel_i,
   input  logic               pg_toggle_i,
   input  logic               feat_toggle_i,
   output logic [NUM_TLB-1:0] all_o,
   output logic [NUM_TLB-1:0] ng_o
);

   logic all_req, ng_req;

   assign all_req = wr_ok_i && (((sel_i == SEL_C0) && pg_toggle_i) ||
                                ((sel_i == SEL_C4) && feat_toggle_i));
   assign ng_req  = wr_ok_i && (sel_i == SEL_C3);

   for (genvar t = 0; t < NUM_TLB; t++) begin : g_tlb
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            all_o[t] <= 1'b0;
            ng_o[t]  <= 1'b0;
         end else begin
            all_o[t] <= all_req;
            ng_o[t]  <= ng_req;
         end
      end
   end

endmodule

// File: rtl/ctlmt_mode.sv
module ctlmt_mode
   import ctlmt_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     upd_i,
   input  logic     lma_i,
   input  logic     l_attr_i,
   input  logic     pe_i,
   input  logic     vm_i,
   output submode_e submode_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni)    submode_o <= SM_REAL;
      else if (upd_i) submode_o <= pick_submode(lma_i, l_attr_i, pe_i, vm_i);
   end

endmodule

// File: rtl/ctlmt_top.sv
module ctlmt_top
   import ctlmt_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter int unsigned IDX_W   = 5,
   parameter int unsigned NUM_TLB = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [XLEN-1:0]    wdata_i,
   input  logic [XLEN-1:0]    cycle_i,
   input  logic               vm_flag_i,
   output logic [XLEN-1:0]    rdata_o,
   output logic               err_o,
   output logic               long_mode_o,
   output logic [2:0]         submode_o,
   output logic [1:0]         cpl_o,
   output logic [NUM_TLB-1:0] flush_all_o,
   output logic [NUM_TLB-1:0] flush_ng_o
);

   localparam logic [XLEN-1:0] ONE    = XLEN'(1);
   localparam logic [XLEN-1:0] ET_M   = ONE << C0_ET;
   localparam logic [XLEN-1:0] LMA_M  = ONE << EXT_LMA;
   localparam logic [XLEN-1:0] FEAT_M = (ONE << C4_PSE) | (ONE << C4_PAE) | (ONE << C4_PGE);

   if (XLEN < 32) begin : g_bad_xlen
      $error("ctlmt_top: XLEN must be at least 32");
   end
   if (IDX_W < 5) begin : g_bad_idx
      $error("ctlmt_top: IDX_W must be at least 5");
   end
   if (NUM_TLB < 1) begin : g_bad_tlb
      $error("ctlmt_top: NUM_TLB must be at least 1");
   end

   sel_e sel;
   logic legal, wr_ok, pg_tog, feat_tog;

   ctlmt_decode #(.IDX_W(IDX_W)) u_dec (
      .idx_i   (idx_i),
      .sel_o   (sel),
      .legal_o (legal)
   );

   assign wr_ok = wr_en_i && legal;

   logic [XLEN-1:0]  c0_q, c2_q, c3_q, c4_q, c8_q, ext_q, tofs_q;
   logic [XLEN-1:0]  c0_n, c2_n, c3_n, c4_n, c8_n, ext_n, tofs_n;
   logic [CSA_W-1:0] csa_q, csa_n;

   assign pg_tog   = c0_q[C0_PG] ^ wdata_i[C0_PG];
   assign feat_tog = |((c4_q ^ wdata_i) & FEAT_M);

   always_comb begin
      c0_n = c0_q; c2_n = c2_q; c3_n = c3_q; c4_n = c4_q; c8_n = c8_q;
      ext_n = ext_q; csa_n = csa_q; tofs_n = tofs_q;
      if (wr_ok) begin
         case (sel)
            SEL_C0: begin
               c0_n = wdata_i | ET_M;
               if (pg_tog && ext_q[EXT_LME]) ext_n[EXT_LMA] = wdata_i[C0_PG];
            end
            SEL_C2:   c2_n   = wdata_i;
            SEL_C3:   c3_n   = wdata_i;
            SEL_C4:   c4_n   = wdata_i;
            SEL_C8:   c8_n   = wdata_i;
            SEL_EXT:  ext_n  = (wdata_i & ~LMA_M) | (ext_q & LMA_M);
            SEL_CSA:  csa_n  = wdata_i[CSA_W-1:0];
            SEL_TOFS: tofs_n = wdata_i - cycle_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         c0_q <= '0; c2_q <= '0; c3_q <= '0; c4_q <= '0; c8_q <= '0;
         ext_q <= '0; csa_q <= '0; tofs_q <= '0;
      end else begin
         c0_q <= c0_n; c2_q <= c2_n; c3_q <= c3_n; c4_q <= c4_n; c8_q <= c8_n;
         ext_q <= ext_n; csa_q <= csa_n; tofs_q <= tofs_n;
      end
   end

   // read path
   logic [XLEN-1:0] rd_val;
   always_comb begin
      case (sel)
         SEL_C0:   rd_val = c0_q | ET_M;
         SEL_C2:   rd_val = c2_q;
         SEL_C3:   rd_val = c3_q;
         SEL_C4:   rd_val = c4_q;
         SEL_C8:   rd_val = c8_q;
         SEL_EXT:  rd_val = ext_q;
         SEL_CSA:  rd_val = XLEN'(csa_q);
         SEL_TOFS: rd_val = tofs_q + cycle_i;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o <= '0;
         err_o   <= 1'b0;
      end else begin
         if (rd_en_i) rdata_o <= rd_val;
         err_o <= (wr_en_i || rd_en_i) && !legal;
      end
   end

   // mode and submode
   submode_e sub_q;

   ctlmt_mode u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_i     (wr_ok),
      .lma_i     (ext_n[EXT_LMA]),
      .l_attr_i  (csa_n[CSA_L]),
      .pe_i      (c0_n[C0_PE]),
      .vm_i      (vm_flag_i),
      .submode_o (sub_q)
   );

   assign submode_o   = sub_q;
   assign long_mode_o = ext_q[EXT_LMA];
   assign cpl_o       = csa_q[1:0];

   ctlmt_flush #(.NUM_TLB(NUM_TLB)) u_flush (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_ok_i       (wr_ok),
      .sel_i         (sel),
      .pg_toggle_i   (pg_tog),
      .feat_toggle_i (feat_tog),
      .all_o         (flush_all_o),
      .ng_o          (flush_ng_o)
   );

   // checks on the state and outputs
   assert_long_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      long_mode_o |-> (sub_q == SM_COMPAT || sub_q == SM_WIDE));

   assert_real_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!long_mode_o && !c0_q[C0_PE]) |-> (sub_q == SM_REAL));

   assert_lma_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(long_mode_o) |-> $past(wr_ok && sel == SEL_C0));

   assert_pg_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && sel == SEL_C0 && pg_tog) |=> (&flush_all_o));

   assert_et_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && sel == SEL_C0) |=> rdata_o[C0_ET]);

   assert_root_ng_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && sel == SEL_C3) |=> (&flush_ng_o));

   assert_illegal_keep_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !legal) |=> (err_o && $stable(c0_q) && $stable(ext_q) &&
                               $stable(csa_q) && $stable(tofs_q)));

endmodule

// File: tb/ctlmt_top_bench.sv
module ctlmt_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  idx = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0, vm = 1'b0;
   logic [63:0] wdata = '0, cyc = 64'd5;
   logic [63:0] rdata;
   logic        err, long_mode;
   logic [2:0]  submode;
   logic [1:0]  cpl, f_all, f_ng;

   always #2 clk = ~clk;                 // 250 MHz
   always @(posedge clk) cyc <= cyc + 64'd13;

   ctlmt_top u_ctlmt_top (
      .clk_i(clk), .rst_ni(rst_n), .idx_i(idx), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .wdata_i(wdata), .cycle_i(cyc), .vm_flag_i(vm), .rdata_o(rdata), .err_o(err),
      .long_mode_o(long_mode), .submode_o(submode), .cpl_o(cpl),
      .flush_all_o(f_all), .flush_ng_o(f_ng)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference model
   logic [63:0] m_c0, m_c2, m_c3, m_c4, m_c8, m_ext, m_cs, m_off;
   int          m_sub;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit m_legal(input int i);
      return (i == 0 || i == 2 || i == 3 || i == 4 || i == 8 ||
              i == 16 || i == 17 || i == 18);
   endfunction

   function automatic logic [63:0] m_read(input int i, input logic [63:0] c);
      case (i)
         0:  return m_c0 | 64'h10;
         2:  return m_c2;
         3:  return m_c3;
         4:  return m_c4;
         8:  return m_c8;
         16: return m_ext;
         17: return m_cs;
         18: return m_off + c;
         default: return 64'd0;
      endcase
   endfunction

   function automatic int calc_sub(input bit lma, input bit l, input bit pe, input bit v);
      if (lma) return l ? 4 : 3;
      if (!pe) return 0;
      return v ? 1 : 2;
   endfunction

   task automatic model_reset();
      m_c0 = 0; m_c2 = 0; m_c3 = 0; m_c4 = 0; m_c8 = 0; m_ext = 0; m_cs = 0; m_off = 0;
      m_sub = 0;
   endtask

   logic [63:0] exp_rd = '0;

   task automatic access(input int i, input logic [63:0] d, input bit w, input bit r);
      logic [63:0] c;
      bit fa, fn, e;
      @(negedge clk);
      idx = 5'(i); wdata = d; wr_en = w; rd_en = r;
      c = cyc;
      fa = 0; fn = 0;
      e = (w || r) && !m_legal(i);
      if (r) exp_rd = m_read(i, c);
      if (w && m_legal(i)) begin
         case (i)
            0: begin
               fa = m_c0[31] ^ d[31];
               if (fa && m_ext[8]) m_ext[10] = d[31];
               m_c0 = d | 64'h10;
            end
            2:  m_c2 = d;
            3: begin m_c3 = d; fn = 1; end
            4: begin fa = |((m_c4 ^ d) & 64'hB0); m_c4 = d; end
            8:  m_c8 = d;
            16: m_ext = (d & ~64'h400) | (m_ext & 64'h400);
            17: m_cs = d & 64'h7;
            18: m_off = d - c;
            default: ;
         endcase
         m_sub = calc_sub(m_ext[10], m_cs[2], m_c0[0], vm);
      end
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      chk("R9 err", 64'(err), 64'(e));
      chk("R4/R7 flush_all", 64'(f_all), fa ? 64'd3 : 64'd0);
      chk("R6 flush_ng", 64'(f_ng), fn ? 64'd3 : 64'd0);
      chk("R2 long_mode", 64'(long_mode), 64'(m_ext[10]));
      chk("R3 submode", 64'(submode), 64'(m_sub));
      chk("R8 cpl", 64'(cpl), m_cs & 64'h3);
      if (r) chk("R11/R10/R5 rdata", rdata, exp_rd);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; rd_en = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      model_reset();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      model_reset();
      do_reset();
      // R1: reset state through reads of every index
      chk("R1 submode", 64'(submode), 64'd0);
      chk("R1 long_mode", 64'(long_mode), 64'd0);
      chk("R1 flush", 64'({f_all, f_ng}), 64'd0);
      for (int i = 0; i < 32; i++) access(i, 64'd0, 0, 1);

      // R9: write sweep over the whole index space, then read back
      for (int i = 0; i < 32; i++)
         access(i, 64'hA5A5_5A5A_F0F0_0F0F ^ 64'(i * 64'h0101_0000_0000_0001), 1, 0);
      for (int i = 0; i < 32; i++) access(i, 64'd0, 0, 1);

      // R2 / R3 / R4: mode sweep
      for (int k = 0; k < 16; k++) begin
         bit lme, pe, l, v;
         lme = k[0]; pe = k[1]; l = k[2]; v = k[3];
         do_reset();
         vm = v;
         access(16, 64'(lme) << 8, 1, 0);
         access(17, (64'(l) << 2) | 64'(k % 4), 1, 0);
         access(0, (64'd1 << 31) | 64'(pe), 1, 0);
         access(16, 64'd0, 0, 1);
         access(17, (64'(!l) << 2) | 64'd3, 1, 0);
         access(0, (64'd1 << 31) | 64'(pe), 1, 0);   // no toggle
         access(0, 64'(pe), 1, 0);
         access(0, 64'd0, 1, 1);
         access(16, 64'h400, 1, 0);                   // R2: LMA not writable
         access(16, 64'd0, 0, 1);
      end
      vm = 0;

      // R7: feature-control bit sweep
      do_reset();
      for (int b = 0; b < 12; b++) begin
         access(4, 64'd1 << b, 1, 0);
         access(4, 64'd0, 1, 0);
      end

      // R6 / R11: root writes, read and write in the same cycle
      access(3, 64'h1234, 1, 0);
      access(3, 64'h5678, 1, 1);
      access(3, 64'h0, 0, 1);
      access(2, 64'hDEAD_BEEF, 1, 1);
      access(2, 64'h0, 0, 1);

      // R10: time offset
      access(18, 64'd1000, 1, 0);
      repeat (5) @(negedge clk);
      access(18, 64'd0, 0, 1);
      access(18, 64'hFFFF_FFFF_FFFF_FFF0, 1, 0);
      access(18, 64'd0, 0, 1);
      access(18, 64'd0, 0, 1);

      // R5: ET forced
      access(0, 64'h0, 1, 1);
      access(0, 64'h0, 0, 1);

      // R9: illegal write leaves neighbours untouched
      access(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
      access(0, 64'h0, 0, 1);
      access(9, 64'h7, 1, 1);

      done = 1;
      finish_run();
   end

endmodule